// File: doc/BRIEF.md
# Two-Cell Configurable Logic Slice

This block is one tile of a programmable logic fabric: two identical logic cells, each built from a 4-input lookup table and a single storage flop. Each cell can drive its output from the table directly or from the flop. The flop's active clock edge can be chosen. So can the value that the set/reset input forces, whether set/reset acts at once or only at the clock edge, and whether the clock-enable input is honoured. A cascade option feeds the first cell's table result into the second cell in place of that cell's top input, which turns the pair into one 5-input function.

All of the slice's behaviour comes from a 44-bit configuration word. The word is shifted in serially while `cfg_load` is high, in the same way as a fabric loaded from configuration memory at power-up. A small control state machine tracks this load:

- `ST_BLANK` is the state after reset, before any load.
- `ST_LOAD` is the state while bits are shifting in.
- `ST_RUN` is normal operation.

The transitions are: `ST_BLANK` → `ST_LOAD` when `cfg_load` is seen high; `ST_LOAD` → `ST_RUN` when `cfg_load` is seen low; `ST_RUN` → `ST_LOAD` when `cfg_load` is seen high again. Outside `ST_RUN`, both outputs are 0 and both flops are held clear.

Top module: `cfg_logic_slice`

## Requirements
- R1: With the combinational output chosen, `y[i]` equals table bit `T[idx]` of cell i, where idx = {in3,in2,in1,in0} is read as an unsigned number and cell i's inputs are `cell_in[4i+3:4i]`.
- R2: Configuration is shifted in one bit per clock while `cfg_load` is high. The first bit shifted is cell 0 table bit 0, followed by table bits 1 to 15. Next come cell 0's control bits in this order: out_reg, edge_neg, ce_use, sr_set, sr_async, cascade. Cell 1 follows in the same layout, giving 44 bits in total.
- R3: After reset, and for every cycle in `ST_LOAD` or `ST_BLANK`, both `y` bits are 0 and both flops are cleared.
- R4: When out_reg is 1, `y[i]` shows the flop, which loads the table output on its active edge. When out_reg is 0, `y[i]` follows the table without delay.
- R5: When edge_neg is 0, the flop captures only on the rising edge of `clk`. When edge_neg is 1, it captures only on the falling edge. It does not change on the other edge.
- R6: When ce_use is 1 and `cell_ce[i]` is 0, the flop holds its value. When ce_use is 0, `cell_ce[i]` has no effect.
- R7: When sr_async is 0, a high `cell_sr[i]` loads sr_set (1 = force to 1, 0 = force to 0) at the next active edge and not before.
- R8: When sr_async is 1, a high `cell_sr[i]` forces the flop to sr_set without waiting for a clock edge, and holds it there while `cell_sr[i]` stays high.
- R9: Set/reset takes priority over both the clock enable and the table data.
- R10: When cell 1's cascade bit is 1, cell 1's input 3 is replaced by cell 0's table output, and `cell_in[7]` has no effect. Cell 0's cascade bit has no effect.
- R11: The state machine enters `ST_LOAD` one clock after `cfg_load` is sampled high. It enters `ST_RUN` one clock after `cfg_load` is sampled low in `ST_LOAD`. It stays in `ST_BLANK` until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; flops can use either edge |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration and state |
| cfg_load | input | 1 | High while configuration bits are being shifted in |
| cfg_din | input | 1 | Serial configuration data, one bit per rising edge |
| cell_in | input | 8 | Table inputs; [3:0] for cell 0, [7:4] for cell 1 |
| cell_ce | input | 2 | Per-cell clock enable |
| cell_sr | input | 2 | Per-cell set/reset request |
| y | output | 2 | Per-cell output |

## Verification
The bench checks the falling-edge cell between edges: a design that clocked it on the rising edge would show the new value half a period late. It holds `cell_ce` low on a cell with ce_use cleared, which exposes a design that honours the enable regardless of the option. It drives a synchronous set with the enable low and the table data 0; a design that gave the enable or the data priority would leave the flop at 0. It also asserts an asynchronous reset between edges, so that a design acting only at the clock would still show 1. The cascade test drives `cell_in[7]` opposite to the cascaded value, and the output flips if that input leaks through. Outputs are checked mid-load, which catches a slice that keeps running while it is reconfigured.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int LUT_K      = 4;
    localparam int LUT_BITS   = 1 << LUT_K;
    localparam int CTRL_BITS  = 6;
    localparam int CELL_BITS  = LUT_BITS + CTRL_BITS;
    localparam int NUM_CELLS  = 2;
    localparam int CFG_BITS   = CELL_BITS * NUM_CELLS;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } cfg_state_e;

    // Packed from MSB to LSB; the table occupies the low bits so that
    // the first bit shifted in lands on table bit 0.
    typedef struct packed {
        logic                casc;
        logic                sr_async;
        logic                sr_set;
        logic                ce_use;
        logic                edge_neg;
        logic                out_reg;
        logic [LUT_BITS-1:0] table_bits;
    } cell_cfg_t;
endpackage

// File: rtl/slice_cfg_ctrl.sv
module slice_cfg_ctrl
    import slice_pkg::*;
#(
    parameter int NBITS = CFG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_din,
    output logic [NBITS-1:0] cfg_bits,
    output logic             run,
    output logic             loading
);
    cfg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (cfg_load)  state_d = ST_LOAD;
            ST_LOAD:  if (!cfg_load) state_d = ST_RUN;
            ST_RUN:   if (cfg_load)  state_d = ST_LOAD;
            default:                 state_d = ST_BLANK;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run     = 1'b0;
        loading = 1'b0;
        unique case (state_q)
            ST_BLANK: ;
            ST_LOAD:  loading = 1'b1;
            ST_RUN:   run     = 1'b1;
            default:  ;
        endcase
    end

    // serial configuration store: new bits enter at the top and move
    // down, so the first bit shifted ends at index 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_bits <= '0;
        else if (cfg_load) cfg_bits <= {cfg_din, cfg_bits[NBITS-1:1]};
    end
endmodule

// File: rtl/slice_lut.sv
module slice_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      sel,
    output logic              o
);
    assign o = table_bits[sel];
endmodule

// File: rtl/slice_cell_ff.sv
module slice_cell_ff (
    input  logic clk,
    input  logic run,
    input  logic edge_neg,
    input  logic ce_use,
    input  logic sr_set,
    input  logic sr_async,
    input  logic d,
    input  logic ce,
    input  logic sr,
    output logic q
);
    logic arst_hit;
    logic arst_val;
    logic cap;
    logic q_rise;
    logic q_fall;

    assign arst_hit = ~run | (sr & sr_async);
    assign arst_val = run & sr_set;
    assign cap      = ~ce_use | ce;

    always_ff @(posedge clk or posedge arst_hit) begin
        if (arst_hit)  q_rise <= arst_val;
        else if (sr)   q_rise <= sr_set;
        else if (cap)  q_rise <= d;
    end

    always_ff @(negedge clk or posedge arst_hit) begin
        if (arst_hit)  q_fall <= arst_val;
        else if (sr)   q_fall <= sr_set;
        else if (cap)  q_fall <= d;
    end

    assign q = edge_neg ? q_fall : q_rise;
endmodule

// File: rtl/slice_cell.sv
module slice_cell
    import slice_pkg::*;
#(
    parameter bit CASCADE_CAP = 1'b0
) (
    input  logic             clk,
    input  logic             run,
    input  cell_cfg_t        cfg,
    input  logic [LUT_K-1:0] in_bits,
    input  logic             casc_in,
    input  logic             ce,
    input  logic             sr,
    output logic             lut_o,
    output logic             reg_q,
    output logic             y
);
    logic [LUT_K-1:0] eff_in;

    generate
        if (CASCADE_CAP) begin : g_casc
            assign eff_in = {cfg.casc ? casc_in : in_bits[LUT_K-1],
                             in_bits[LUT_K-2:0]};
        end else begin : g_plain
            logic unused_casc;
            assign unused_casc = casc_in ^ cfg.casc;
            assign eff_in      = in_bits;
        end
    endgenerate

    slice_lut #(.K(LUT_K)) lut_i (
        .table_bits (cfg.table_bits),
        .sel        (eff_in),
        .o          (lut_o)
    );

    slice_cell_ff ff_i (
        .clk      (clk),
        .run      (run),
        .edge_neg (cfg.edge_neg),
        .ce_use   (cfg.ce_use),
        .sr_set   (cfg.sr_set),
        .sr_async (cfg.sr_async),
        .d        (lut_o),
        .ce       (ce),
        .sr       (sr),
        .q        (reg_q)
    );

    assign y = run & (cfg.out_reg ? reg_q : lut_o);
endmodule

// File: rtl/cfg_logic_slice.sv
module cfg_logic_slice
    import slice_pkg::*;
#(
    parameter int CELLS = NUM_CELLS,
    parameter int K     = LUT_K
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic               cfg_din,
    input  logic [CELLS*K-1:0] cell_in,
    input  logic [CELLS-1:0]   cell_ce,
    input  logic [CELLS-1:0]   cell_sr,
    output logic [CELLS-1:0]   y
);
    localparam int NBITS = CELLS * CELL_BITS;

    logic [NBITS-1:0] cfg_bits;
    logic             run;
    logic             loading;
    logic [CELLS-1:0] lut_o;
    logic [CELLS-1:0] reg_q;

    slice_cfg_ctrl #(.NBITS(NBITS)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_din  (cfg_din),
        .cfg_bits (cfg_bits),
        .run      (run),
        .loading  (loading)
    );

    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_cell
            cell_cfg_t cfg_i;
            logic      casc_src;
            assign cfg_i = cell_cfg_t'(cfg_bits[i*CELL_BITS +: CELL_BITS]);
            if (i == 0) begin : g_first
                assign casc_src = 1'b0;
            end else begin : g_next
                assign casc_src = lut_o[i-1];
            end
            slice_cell #(.CASCADE_CAP(i != 0)) cell_i (
                .clk     (clk),
                .run     (run),
                .cfg     (cfg_i),
                .in_bits (cell_in[i*K +: K]),
                .casc_in (casc_src),
                .ce      (cell_ce[i]),
                .sr      (cell_sr[i]),
                .lut_o   (lut_o[i]),
                .reg_q   (reg_q[i]),
                .y       (y[i])
            );
        end
    endgenerate
endmodule

// File: rtl/slice_chk.sv
module slice_chk
    import slice_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_load,
    input logic                      run,
    input logic                      loading,
    input logic [NUM_CELLS-1:0]      y,
    input logic [NUM_CELLS-1:0]      cell_ce,
    input logic [NUM_CELLS-1:0]      cell_sr,
    input logic [NUM_CELLS-1:0]      reg_q,
    input logic [CFG_BITS-1:0]       cfg_bits
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (y == '0)); // R3

    AST_LOAD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> loading); // R11

    AST_LOAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && !cfg_load) |=> run); // R11

    AST_BLANK_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!loading && !run && !cfg_load) |=> !run); // R11

    generate
        for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
            cell_cfg_t c;
            assign c = cell_cfg_t'(cfg_bits[i*CELL_BITS +: CELL_BITS]);

            AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !cfg_load && c.ce_use && !c.edge_neg && !c.sr_async
                 && !cell_ce[i] && !cell_sr[i]) |=> $stable(reg_q[i])); // R6

            AST_SYNC_SR: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !cfg_load && !c.edge_neg && !c.sr_async && cell_sr[i])
                |=> (reg_q[i] == c.sr_set)); // R9
        end
    endgenerate
endmodule

bind cfg_logic_slice slice_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .run      (run),
    .loading  (loading),
    .y        (y),
    .cell_ce  (cell_ce),
    .cell_sr  (cell_sr),
    .reg_q    (reg_q),
    .cfg_bits (cfg_bits)
);

// File: tb/cfg_logic_slice_tb_top.sv
module cfg_logic_slice_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cfg_din = 1'b0;
    logic [7:0] cell_in = '0;
    logic [1:0] cell_ce = '0;
    logic [1:0] cell_sr = '0;
    logic [1:0] y;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    cfg_logic_slice dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_din(cfg_din),
        .cell_in(cell_in), .cell_ce(cell_ce), .cell_sr(cell_sr), .y(y)
    );

    // {c0_in, c1_in, expected y}; cell 0 = 4-input parity, cell 1 = 4-input AND
    localparam logic [9:0] VEC [8] = '{
        {4'b0000, 4'b0000, 2'b00},
        {4'b0001, 4'b1111, 2'b11},
        {4'b0011, 4'b1110, 2'b00},
        {4'b0111, 4'b1111, 2'b11},
        {4'b1111, 4'b0111, 2'b00},
        {4'b1000, 4'b1111, 2'b11},
        {4'b1010, 4'b1011, 2'b00},
        {4'b1110, 4'b1111, 2'b11}
    };

    function automatic logic [21:0] mk(input logic [15:0] t, input logic oreg,
        input logic eneg, input logic ceu, input logic sset,
        input logic sasync, input logic casc);
        return {casc, sasync, sset, ceu, eneg, oreg, t};
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: y=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // shift 44 bits, first bit = v[0]; optional mid-load output check
    task automatic load(input logic [43:0] v, input bit mid_check);
        @(negedge clk);
        cfg_load = 1'b1;
        for (int i = 0; i < 44; i++) begin
            cfg_din = v[i];
            @(negedge clk);
            if (mid_check && i == 20) chk("R3 outputs quiet during load", y, 2'b00);
        end
        cfg_load = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: y=%b expected completion", y);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cell_in = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R3 reset output", y, 2'b00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 blank until first load", y, 2'b00);

        // R1/R4 all-ones comb tables
        load({mk(16'hFFFF,0,0,0,0,0,0), mk(16'hFFFF,0,0,0,0,0,0)}, 1'b0);
        chk("R1 constant-one tables", y, 2'b11);

        // R1 vector walk; reload with mid-load quiet check (R3, R11)
        load({mk(16'h8000,0,0,0,0,0,0), mk(16'h6996,0,0,0,0,0,0)}, 1'b1);
        for (int k = 0; k < 8; k++) begin
            cell_in = {VEC[k][5:2], VEC[k][9:6]};
            #1;
            chk("R1 table lookup", y, VEC[k][1:0]);
            @(negedge clk);
        end

        // R10 cascade: cell0 AND, cell1 parity with in3 from cell0 (R2 bit 43)
        load({mk(16'h6996,0,0,0,0,0,1), mk(16'h8000,0,0,0,0,0,0)}, 1'b0);
        cell_in = {4'b1000, 4'b0000}; #1;
        chk("R10 cascade ignores cell_in[7]", y, 2'b00);
        cell_in = {4'b1000, 4'b1111}; #1;
        chk("R10 cascade from cell0", y, 2'b11);
        cell_in = {4'b0000, 4'b1111}; #1;
        chk("R10 cascade with input low", y, 2'b11);
        cell_in = {4'b0001, 4'b0000}; #1;
        chk("R10 cascade low bits", y, 2'b10);

        // R4/R5/R6: cell0 rising, ce honoured; cell1 falling, ce ignored
        cell_in = '0; cell_ce = '0;
        load({mk(16'hAAAA,1,1,0,0,0,0), mk(16'hAAAA,1,0,1,0,0,0)}, 1'b0);
        chk("R3 flops clear after load", y, 2'b00);
        @(posedge clk); #1;
        cell_in = 8'h11; cell_ce = 2'b01;
        #2;
        chk("R4 registered output waits for edge", y, 2'b00);
        @(negedge clk); #1;
        chk("R5 falling-edge cell only", y, 2'b10);
        @(posedge clk); #1;
        chk("R5 rising-edge cell captures", y, 2'b11);
        cell_in = 8'h00; cell_ce = 2'b00;
        @(negedge clk); #1;
        chk("R6 ce ignored when unused", y, 2'b01);
        @(posedge clk); #1;
        chk("R6 ce low holds", y, 2'b01);
        cell_ce = 2'b01;
        @(posedge clk); #1;
        chk("R6 ce high captures", y, 2'b00);

        // R7/R8/R9: cell0 sync set (table 0); cell1 async reset (table 1)
        cell_ce = '0; cell_sr = '0;
        load({mk(16'hFFFF,1,0,0,0,1,0), mk(16'h0000,1,0,1,1,0,0)}, 1'b0);
        @(posedge clk); #1;
        chk("R4 cell1 registered one", y, 2'b10);
        cell_sr = 2'b01;
        #2;
        chk("R7 sync set waits for edge", y, 2'b10);
        @(posedge clk); #1;
        chk("R9 set beats ce and data", y, 2'b11);
        cell_sr = 2'b10;
        #1;
        chk("R8 async reset immediate", y, 2'b01);
        @(posedge clk); #1;
        chk("R8 async reset holds", y, 2'b01);
        cell_sr = 2'b00;
        @(posedge clk); #1;
        chk("R7 release resumes data", y, 2'b11);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule